// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar date in packed BCD registers. A one-cycle enable arriving at 4096 Hz feeds a fractional divider that emits one advance pulse per hundredth of a second. On each advance the counters ripple through hundredths, seconds, minutes, hours, weekday, date, month and year. Month lengths and leap years are resolved inside the ripple. The hour field runs in either a 24-hour or a 12-hour AM/PM encoding.

A host loads any field through a simple write port. It reads any field through a combinational read port. The read port returns either the live counters or a frozen copy, which is taken whenever the host pulses a capture strobe. A multi-field read from the frozen copy is therefore coherent while the live counters keep running.

The divider is a two-state machine. `PS_LONG` counts periods of `LONG_DIV` ticks. `PS_LONG -> PS_SHORT` is taken at the end of the `LONG_RUNS`-th long period. `PS_SHORT` counts one period of `SHORT_DIV` ticks, and `PS_SHORT -> PS_LONG` is taken at its end. A host write forces `PS_LONG` with the counts cleared.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset or after any host write, the divider emits its advance pulse `centi_pulse` in the cycle after the 41st tick. This repeats for 24 periods, then one period of 40 ticks follows, and the pattern repeats. 1023 ticks therefore yield 24 pulses and 1024 ticks yield 25. The pulse is one cycle wide.
- R2: Hundredths count BCD 00–99. Seconds and minutes count BCD 00–59. Each field wraps to 00 and carries into the next one up.
- R3: When hour bit 6 is 0 (24-hour mode), bits 5:0 hold BCD 00–23. 23 wraps to 00 and carries into the day fields.
- R4: When hour bit 6 is 1 (12-hour mode), bit 5 is 1 for PM and bits 4:0 hold BCD 01–12. The sequences are 09→10, 11 AM→12 PM, 12→01 with bit 5 kept, and 11 PM→12 AM. Only the 11 PM→12 AM step carries into the day fields.
- R5: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months. February wraps after 29 when the BCD year is divisible by 4 (00 included) and after 28 otherwise.
- R6: On a day carry the weekday advances and wraps 7→1. A date wrap advances the month, and the month wraps 12→01 carrying into the year. The year wraps 99→00.
- R7: Field addresses are 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month and 7 year. A write with `wr_en` loads the addressed field on the next edge. Stored widths are 8, 7, 7, 7, 3, 6, 5 and 8 bits, and the upper bits read as 0. A write restarts the divider in `PS_LONG`. An advance pulse that falls in the same cycle as a write is discarded for every field.
- R8: `snap_req` copies all eight live fields into the frozen copy on the next edge. The frozen copy changes at no other time. `rd_shadow`=1 selects the frozen copy for `rd_data`, and 0 selects the live fields.
- R9: Reset loads 00:00:00.00 in 24-hour mode, weekday 1, date 01, month 01 and year 00, into both the live fields and the frozen copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle 4096 Hz time base enable |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field address for write |
| wr_data | input | 8 | BCD value to write |
| snap_req | input | 1 | Capture live fields into the frozen copy |
| rd_shadow | input | 1 | 1 reads the frozen copy, 0 reads live fields |
| rd_addr | input | 3 | Field address for read |
| rd_data | output | 8 | Selected field value |
| centi_pulse | output | 1 | Hundredth-second advance pulse |

## Verification
The checker assumes the host writes only legal BCD values in range for each field. It also assumes `tick_en` never stays high for long enough to produce two pulses closer together than 40 ticks. It further assumes that the year field changes only through a write or a year carry. The bench writes only legal calendar settings taken from its vector table, and it paces ticks by a fixed divider or by a task that drives single ticks. It places its same-cycle write and advance collision at an exactly counted tick position.

// File: rtl/bcd_tk_pkg.sv
package bcd_tk_pkg;

    localparam int NUM_FIELDS = 8;
    localparam int FA_W       = $clog2(NUM_FIELDS);

    localparam int IDX_CENTI = 0;
    localparam int IDX_SEC   = 1;
    localparam int IDX_MIN   = 2;
    localparam int IDX_HOUR  = 3;
    localparam int IDX_WDAY  = 4;
    localparam int IDX_DATE  = 5;
    localparam int IDX_MONTH = 6;
    localparam int IDX_YEAR  = 7;

    typedef logic [7:0] bcd_t;

    typedef enum logic [0:0] {
        PS_LONG  = 1'b0,
        PS_SHORT = 1'b1
    } ps_state_e;

    function automatic bcd_t bcd_inc(input bcd_t v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd_to_bin(input bcd_t v);
        return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
    endfunction

    function automatic logic leap_year(input bcd_t yr);
        logic [6:0] b;
        b = bcd_to_bin(yr);
        return (b[1:0] == 2'b00);
    endfunction

    function automatic bcd_t month_last_day(input bcd_t mon, input bcd_t yr);
        unique case (mon)
            8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // returns {day_carry, next_hour}
    function automatic logic [8:0] hour_step(input bcd_t h);
        logic [4:0] v;
        if (!h[6]) begin
            if (h[5:0] == 6'h23) return {1'b1, 8'h00};
            else                 return {1'b0, bcd_inc({2'b00, h[5:0]})};
        end
        v = h[4:0];
        if (v == 5'h12)      return {1'b0, 1'b0, 1'b1, h[5], 5'h01};
        else if (v == 5'h11) return {h[5], 1'b0, 1'b1, ~h[5], 5'h12};
        else begin
            bcd_t t;
            t = bcd_inc({3'b000, v});
            return {1'b0, 1'b0, 1'b1, h[5], t[4:0]};
        end
    endfunction

    function automatic bcd_t field_mask(input int idx);
        unique case (idx)
            IDX_SEC, IDX_MIN, IDX_HOUR: return 8'h7F;
            IDX_WDAY:                   return 8'h07;
            IDX_DATE:                   return 8'h3F;
            IDX_MONTH:                  return 8'h1F;
            default:                    return 8'hFF;
        endcase
    endfunction

    function automatic bcd_t field_init(input int idx);
        unique case (idx)
            IDX_WDAY, IDX_DATE, IDX_MONTH: return 8'h01;
            default:                       return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/bcd_tk_prescaler.sv
module bcd_tk_prescaler
    import bcd_tk_pkg::*;
#(
    parameter int LONG_DIV  = 41,
    parameter int SHORT_DIV = 40,
    parameter int LONG_RUNS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic clr,
    output logic pulse_o
);

    localparam int CW = $clog2(LONG_DIV);
    localparam int RW = (LONG_RUNS > 1) ? $clog2(LONG_RUNS) : 1;
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_DIV - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_DIV - 1);
    localparam logic [RW-1:0] RUN_LAST   = RW'(LONG_RUNS - 1);

    ps_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic [RW-1:0]   run_q;
    logic            period_end;

    always_comb begin
        unique case (state_q)
            PS_LONG:  period_end = tick_en && (cnt_q == LONG_LAST);
            PS_SHORT: period_end = tick_en && (cnt_q == SHORT_LAST);
            default:  period_end = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_LONG:  if (period_end && run_q == RUN_LAST) state_d = PS_SHORT;
            PS_SHORT: if (period_end)                      state_d = PS_LONG;
            default:  state_d = PS_LONG;
        endcase
        if (clr) state_d = PS_LONG;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_LONG;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q   <= '0;
            run_q   <= '0;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= period_end;
            if (period_end) begin
                cnt_q <= '0;
                if (state_q == PS_LONG && run_q != RUN_LAST) run_q <= run_q + 1'b1;
                else                                         run_q <= '0;
            end else if (tick_en) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bcd_tk_chain.sv
module bcd_tk_chain
    import bcd_tk_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          adv,
    input  logic                          wr_en,
    input  logic [FA_W-1:0]               wr_addr,
    input  logic [7:0]                    wr_data,
    output logic [NUM_FIELDS-1:0][7:0]    live_o
);

    logic [NUM_FIELDS-1:0][7:0] cur;
    logic [NUM_FIELDS-1:0][7:0] nxt;
    logic [8:0] hstep;
    bcd_t       last_day;
    logic       c_sec, c_min, c_hr, c_day, c_mon, c_yr;

    always_comb begin
        nxt      = cur;
        hstep    = hour_step(cur[IDX_HOUR]);
        last_day = month_last_day(cur[IDX_MONTH], cur[IDX_YEAR]);

        c_sec = (cur[IDX_CENTI] == 8'h99);
        c_min = c_sec && (cur[IDX_SEC] == 8'h59);
        c_hr  = c_min && (cur[IDX_MIN] == 8'h59);
        c_day = c_hr  && hstep[8];
        c_mon = c_day && (cur[IDX_DATE] == last_day);
        c_yr  = c_mon && (cur[IDX_MONTH] == 8'h12);

        nxt[IDX_CENTI] = c_sec ? 8'h00 : bcd_inc(cur[IDX_CENTI]);
        if (c_sec) nxt[IDX_SEC] = (cur[IDX_SEC] == 8'h59) ? 8'h00 : bcd_inc(cur[IDX_SEC]);
        if (c_min) nxt[IDX_MIN] = (cur[IDX_MIN] == 8'h59) ? 8'h00 : bcd_inc(cur[IDX_MIN]);
        if (c_hr)  nxt[IDX_HOUR] = hstep[7:0];
        if (c_day) begin
            nxt[IDX_WDAY] = (cur[IDX_WDAY] == 8'h07) ? 8'h01 : cur[IDX_WDAY] + 8'h01;
            nxt[IDX_DATE] = (cur[IDX_DATE] == last_day) ? 8'h01 : bcd_inc(cur[IDX_DATE]);
        end
        if (c_mon) nxt[IDX_MONTH] = (cur[IDX_MONTH] == 8'h12) ? 8'h01 : bcd_inc(cur[IDX_MONTH]);
        if (c_yr)  nxt[IDX_YEAR]  = (cur[IDX_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cur[IDX_YEAR]);
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        localparam bcd_t MASK = field_mask(g);
        localparam bcd_t INIT = field_init(g);
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)                                q <= INIT;
            else if (wr_en && wr_addr == FA_W'(g))     q <= wr_data & MASK;
            else if (!wr_en && adv)                    q <= nxt[g];
        end
        assign cur[g] = q;
    end

    assign live_o = cur;

endmodule

// File: rtl/bcd_tk_shadow.sv
module bcd_tk_shadow
    import bcd_tk_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       snap,
    input  logic [NUM_FIELDS-1:0][7:0] live_i,
    output logic [NUM_FIELDS-1:0][7:0] shadow_o
);

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_copy
        localparam bcd_t INIT = field_init(g);
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)    q <= INIT;
            else if (snap) q <= live_i[g];
        end
        assign shadow_o[g] = q;
    end

endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
    import bcd_tk_pkg::*;
#(
    parameter int LONG_DIV  = 41,
    parameter int SHORT_DIV = 40,
    parameter int LONG_RUNS = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       snap_req,
    input  logic       rd_shadow,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       centi_pulse
);

    logic [NUM_FIELDS-1:0][7:0] live;
    logic [NUM_FIELDS-1:0][7:0] frozen;

    bcd_tk_prescaler #(
        .LONG_DIV  (LONG_DIV),
        .SHORT_DIV (SHORT_DIV),
        .LONG_RUNS (LONG_RUNS)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .clr     (wr_en),
        .pulse_o (centi_pulse)
    );

    bcd_tk_chain u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (centi_pulse),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .live_o  (live)
    );

    bcd_tk_shadow u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .snap     (snap_req),
        .live_i   (live),
        .shadow_o (frozen)
    );

    assign rd_data = rd_shadow ? frozen[rd_addr] : live[rd_addr];

endmodule

// File: rtl/bcd_timekeeper_chk.sv
module bcd_timekeeper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_en,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       snap_req,
    input logic       rd_shadow,
    input logic [2:0] rd_addr,
    input logic [7:0] rd_data,
    input logic       centi_pulse
);

    logic [15:0] tcnt;

    always_ff @(posedge clk) begin
        if (!rst_n)           tcnt <= '0;
        else if (wr_en)       tcnt <= '0;
        else if (centi_pulse) tcnt <= tick_en ? 16'd1 : 16'd0;
        else if (tick_en)     tcnt <= tcnt + 16'd1;
    end

    a_r1_period_len: assert property (@(posedge clk) disable iff (!rst_n)
        centi_pulse |-> (tcnt == 16'd40 || tcnt == 16'd41));

    a_r1_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        centi_pulse |=> !centi_pulse);

    a_r2_centi_digits: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_shadow && rd_addr == 3'd0) |-> (rd_data[7:4] <= 4'd9 && rd_data[3:0] <= 4'd9));

    a_r2_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_shadow && rd_addr == 3'd1) |-> (rd_data[7] == 1'b0 && rd_data[6:4] <= 3'd5));

    a_r7_year_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_shadow && rd_addr == 3'd7 && $past(wr_en) && $past(wr_addr) == 3'd7)
        |-> rd_data == $past(wr_data));

    a_r8_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_shadow && $past(rd_shadow) && rd_addr == $past(rd_addr) && !$past(snap_req))
        |-> $stable(rd_data));

endmodule

bind bcd_timekeeper bcd_timekeeper_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .snap_req    (snap_req),
    .rd_shadow   (rd_shadow),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .centi_pulse (centi_pulse)
);

// File: tb/bcd_timekeeper_tb_top.sv
`timescale 1ns/1ps
module bcd_timekeeper_tb_top;

    localparam int TICK_DIV = 4;
    localparam int NVEC     = 14;

    // {hour, wday, date, month, year, exp_hour, exp_wday, exp_date, exp_month, exp_year}
    localparam logic [79:0] VEC [NVEC] = '{
        80'h23_07_28_02_23_00_01_01_03_23,
        80'h23_03_28_02_24_00_04_29_02_24,
        80'h23_04_29_02_24_00_05_01_03_24,
        80'h23_02_31_12_99_00_03_01_01_00,
        80'h23_01_30_04_10_00_02_01_05_10,
        80'h23_01_30_01_10_00_02_31_01_10,
        80'h51_05_15_06_05_72_05_15_06_05,
        80'h71_06_30_06_05_52_07_01_07_05,
        80'h72_05_15_06_05_61_05_15_06_05,
        80'h09_02_10_03_30_10_02_10_03_30,
        80'h49_03_10_03_30_50_03_10_03_30,
        80'h23_03_30_11_21_00_04_01_12_21,
        80'h23_07_28_02_00_00_01_29_02_00,
        80'h23_05_30_09_21_00_06_01_10_21
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_gen = 1'b0;
    logic       tick_man = 1'b0;
    logic       tick_en;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       snap_req = 1'b0;
    logic       rd_shadow = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       centi_pulse;
    logic       tick_auto = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    assign tick_en = tick_gen | tick_man;

    always #2.5 clk = ~clk;

    bcd_timekeeper dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .snap_req    (snap_req),
        .rd_shadow   (rd_shadow),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .centi_pulse (centi_pulse)
    );

    initial begin
        int phase;
        phase = 0;
        forever begin
            @(negedge clk);
            if (tick_auto && phase == TICK_DIV - 1) begin
                tick_gen = 1'b1;
                phase = 0;
            end else begin
                tick_gen = 1'b0;
                if (tick_auto) phase++;
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_field(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_field(input logic sh, input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_shadow = sh; rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic send_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_man = 1'b1;
            @(negedge clk); tick_man = 1'b0;
        end
    endtask

    initial begin
        logic [7:0] v;
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] init_vals [8];
        init_vals = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset values, live and frozen
        for (int f = 0; f < 8; f++) begin
            read_field(1'b0, 3'(f), v); check("R9 live", v, init_vals[f]);
            read_field(1'b1, 3'(f), v); check("R9 frozen", v, init_vals[f]);
        end

        // R1: 1023 ticks -> 24 pulses, 1024 -> 25
        write_field(3'd0, 8'h00);
        send_ticks(1023);
        read_field(1'b0, 3'd0, v); check("R1 1023 ticks", v, 8'h24);
        send_ticks(1);
        read_field(1'b0, 3'd0, v); check("R1 1024 ticks", v, 8'h25);

        // R7: write wins over coincident advance; R8 capture
        write_field(3'd0, 8'h42);
        send_ticks(40);
        @(negedge clk); tick_man = 1'b1;
        @(negedge clk); tick_man = 1'b0;
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h30;
        @(negedge clk); wr_en = 1'b0;
        read_field(1'b0, 3'd0, v); check("R7 advance dropped", v, 8'h42);
        read_field(1'b0, 3'd1, v); check("R7 written sec", v, 8'h30);
        write_field(3'd5, 8'hFF);
        read_field(1'b0, 3'd5, v); check("R7 date mask", v, 8'h3F);
        write_field(3'd5, 8'h12);
        @(negedge clk); snap_req = 1'b1;
        @(negedge clk); snap_req = 1'b0;
        send_ticks(41);
        read_field(1'b0, 3'd0, v); check("R8 live moved", v, 8'h43);
        read_field(1'b1, 3'd0, v); check("R8 frozen held", v, 8'h42);
        read_field(1'b1, 3'd1, v); check("R8 frozen sec", v, 8'h30);
        read_field(1'b1, 3'd5, v); check("R8 frozen date", v, 8'h12);

        // R2: seconds carry without minute carry
        write_field(3'd1, 8'h09);
        write_field(3'd0, 8'h99);
        send_ticks(41);
        read_field(1'b0, 3'd0, v); check("R2 centi wrap", v, 8'h00);
        read_field(1'b0, 3'd1, v); check("R2 sec carry", v, 8'h10);

        // R3 R4 R5 R6: vector table, each at 59:59.99
        tick_auto = 1'b1;
        for (int k = 0; k < NVEC; k++) begin
            logic [79:0] r;
            r = VEC[k];
            write_field(3'd3, r[79:72]);
            write_field(3'd4, r[71:64]);
            write_field(3'd5, r[63:56]);
            write_field(3'd6, r[55:48]);
            write_field(3'd7, r[47:40]);
            write_field(3'd2, 8'h59);
            write_field(3'd1, 8'h59);
            write_field(3'd0, 8'h99);
            do @(negedge clk); while (!centi_pulse);
            read_field(1'b0, 3'd1, v); check("R2 sec wrap", v, 8'h00);
            read_field(1'b0, 3'd2, v); check("R2 min wrap", v, 8'h00);
            read_field(1'b0, 3'd3, v); check("R3/R4 hour", v, r[39:32]);
            read_field(1'b0, 3'd4, v); check("R6 weekday", v, r[31:24]);
            read_field(1'b0, 3'd5, v); check("R5 date", v, r[23:16]);
            read_field(1'b0, 3'd6, v); check("R6 month", v, r[15:8]);
            read_field(1'b0, 3'd7, v); check("R6 year", v, r[7:0]);
        end
        tick_auto = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule